// File: doc/BRIEF.md
# System Clock Control Register Pair with Write Protection

This block holds the two byte-wide registers that steer a chip's clock generator, plus the protect register that guards them. A simple byte bus (address, write strobe, write data, combinational read data) reaches all three. The control register writes take effect only while the enable bit of the protect register is set. The protect register itself can always be written, and all three registers can always be read.

The stored bits drive the clock generator as plain control outputs:
- the clock-output pin function;
- peripheral clock gating in wait mode;
- the sub-oscillator enable and its drive strength;
- the main-oscillator stop;
- the watchdog action;
- the system clock source;
- the stop-mode request.

The oscillators are outside the block, and it sees each of them only as a "stable" flag. Before it changes the clock source it checks that the target oscillator is enabled and stable. It refuses writes that break the ordering rules, and for each refused write it raises a one-cycle error pulse. It also tells the main clock divider to load its divide-by-8 setting whenever the main oscillator is stopped or stop mode is entered.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, control register 0 (address 0) reads 0x08, control register 1 (address 1) reads 0x20, the protect register (address 2) reads 0x00, and any other address reads 0x00. Reads are valid at any time, whatever the protect bit.
- R2: A write to address 0 or 1 changes nothing unless protect bit 0 is 1. The protect register is always writable, keeps only bit 0, and reads 0 in bits 7:1.
- R3: The outputs follow the stored bits of register 0:
  - bits 1:0 give the clock-output select (00 port, 01 fC, 10 f8, 11 f32);
  - bit 2 gives wait-mode peripheral clock stop;
  - bit 3 gives sub-oscillator high drive;
  - bit 4 gives sub-oscillator enable;
  - bit 5 gives main-oscillator stop;
  - bit 6 gives watchdog reset mode;
  - bit 7 gives sub-clock as system clock.
- R4: Register 0 bit 6 is sticky. Once it is 1, a write of 0 leaves it at 1.
- R5: A write that takes bit 7 from 0 to 1 is accepted only if the stored bit 4 is 1 and `sub_stable` is 1.
- R6: A write that takes bit 7 from 1 to 0 is accepted only if the stored bit 5 is 0 and `main_stable` is 1.
- R7: A write that takes bit 5 from 0 to 1 is accepted only while the stored bit 7 is 1.
- R8: A write that changes both bit 4 and bit 5 of register 0 is refused.
- R9: A refused register 0 write leaves every bit of register 0 unchanged, and `wr_err` is 1 for exactly the cycle after the write.
- R10: In register 1, bit 0 is the stop-mode request and bit 5 is main-oscillator high drive. All other bits always read 0.
- R11: Stop-mode entry is an accepted register 1 write that takes bit 0 from 0 to 1. On entry, register 0 bit 3 is forced to 1. Register 1 bit 5 is forced to 1 only if `speed_hm` is 1.
- R12: A `wake` pulse clears register 1 bit 0 at the next clock edge. This takes priority over a register 1 write in the same cycle, and such a write does not count as stop-mode entry.
- R13: `div8_load` is 1 for exactly the cycle after one of these accepted writes:
  - a register 0 write that takes bit 5 from 0 to 1;
  - a register 1 write that enters stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| sub_stable | input | 1 | Sub oscillator is running and stable |
| main_stable | input | 1 | Main oscillator is running and stable |
| speed_hm | input | 1 | Chip is in high- or middle-speed mode |
| wake | input | 1 | Wake-up pulse that ends stop mode |
| clkout_sel | output | 2 | Clock-output pin function select |
| wait_periph_stop | output | 1 | Gate peripheral clocks in wait mode |
| sub_drive_hi | output | 1 | Sub oscillator high drive |
| sub_osc_en | output | 1 | Sub oscillator enable |
| main_osc_stop | output | 1 | Main oscillator stop |
| wdt_reset_mode | output | 1 | Watchdog triggers reset rather than interrupt |
| sysclk_sub | output | 1 | System clock taken from the sub oscillator |
| main_drive_hi | output | 1 | Main oscillator high drive |
| stop_req | output | 1 | Stop mode (all clocks off) requested |
| div8_load | output | 1 | Load divide-by-8 into the main clock divider |
| wr_err | output | 1 | A register 0 write was refused |

## Verification
The bench works through each refused-write rule in turn:
- a switch to the sub clock with the sub oscillator disabled, and then with it enabled but unstable;
- a return to the main clock while the main oscillator is stopped or unstable;
- a main-oscillator stop while the main clock is still the system clock;
- a single write that flips both oscillator bits.

A design that checked the new value in place of the stored one, or that merged part of a refused write, would leave register 0 different from the model or miss the `wr_err` pulse.

The bench also covers the remaining corner cases:
- clearing the watchdog bit after it has been set;
- stop-mode entry with and without `speed_hm`;
- a wake pulse that lands in the same cycle as a register 1 write;
- writes while the protect bit is clear.

These catch a watchdog bit that can be cleared, a drive bit forced in the wrong speed mode, and a write that wins over wake. A randomised phase then compares every output and every read against a behavioural model on each clock.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    CKO_PORT = 2'b00,
    CKO_FC   = 2'b01,
    CKO_F8   = 2'b10,
    CKO_F32  = 2'b11
  } cko_sel_e;

  // register 0 bit positions
  localparam int B0_WAITSTOP = 2;
  localparam int B0_SUBDRV   = 3;
  localparam int B0_SUBEN    = 4;
  localparam int B0_MSTOP    = 5;
  localparam int B0_WDT      = 6;
  localparam int B0_SYS      = 7;

  // register 1 bit positions
  localparam int B1_STOP = 0;
  localparam int B1_MDRV = 5;

  localparam logic [REG_W-1:0] CTL0_RST  = 8'h08;
  localparam logic [REG_W-1:0] CTL1_RST  = 8'h20;
  localparam logic [REG_W-1:0] CTL1_KEEP = 8'h21;

  // A register 0 write that breaks an ordering rule, judged against stored state
  function automatic logic ctl0_reject(input logic [REG_W-1:0] cur,
                                       input logic [REG_W-1:0] nxt,
                                       input logic sub_ok,
                                       input logic main_ok);
    logic flip45, to_sub, to_main, stop_main;
    flip45    = (cur[B0_SUBEN] ^ nxt[B0_SUBEN]) & (cur[B0_MSTOP] ^ nxt[B0_MSTOP]);
    to_sub    = !cur[B0_SYS] & nxt[B0_SYS] & !(cur[B0_SUBEN] & sub_ok);
    to_main   = cur[B0_SYS] & !nxt[B0_SYS] & !(!cur[B0_MSTOP] & main_ok);
    stop_main = !cur[B0_MSTOP] & nxt[B0_MSTOP] & !cur[B0_SYS];
    return flip45 | to_sub | to_main | stop_main;
  endfunction

  // Accepted register 0 value: write data with the watchdog bit kept sticky
  function automatic logic [REG_W-1:0] ctl0_merge(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] nxt);
    logic [REG_W-1:0] r;
    r         = nxt;
    r[B0_WDT] = cur[B0_WDT] | nxt[B0_WDT];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] ctl1_clean(input logic [REG_W-1:0] nxt);
    return nxt & CTL1_KEEP;
  endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode #(
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_CTL0 = 0,
  parameter logic [ADDR_W-1:0] A_CTL1 = 1,
  parameter logic [ADDR_W-1:0] A_PROT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  output logic              prot_en,
  output logic              wr_ctl0,
  output logic              wr_ctl1
);

  logic hit_prot;
  assign hit_prot = wr_en && (addr == A_PROT);
  assign wr_ctl0  = wr_en && (addr == A_CTL0) && prot_en;
  assign wr_ctl1  = wr_en && (addr == A_CTL1) && prot_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prot_en <= 1'b0;
    else if (hit_prot) prot_en <= wbit0;
  end

  AST_PROT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_prot |=> (prot_en == $past(wbit0))) else $error("protect write lost"); // R2

endmodule

// File: rtl/clkctl_reg0.sv
module clkctl_reg0
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             sub_stable,
  input  logic             main_stable,
  input  logic             stop_enter,
  output logic [REG_W-1:0] q,
  output logic             rej,
  output logic             mstop_rise
);

  logic accept;
  logic flip45;

  assign rej        = wr && ctl0_reject(q, wdata, sub_stable, main_stable);
  assign accept     = wr && !rej;
  assign mstop_rise = accept && wdata[B0_MSTOP] && !q[B0_MSTOP];
  assign flip45     = (q[B0_SUBEN] != wdata[B0_SUBEN]) && (q[B0_MSTOP] != wdata[B0_MSTOP]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTL0_RST;
    else begin
      if (accept)     q <= ctl0_merge(q, wdata);
      if (stop_enter) q[B0_SUBDRV] <= 1'b1;
    end
  end

  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q[B0_WDT] |=> q[B0_WDT]) else $error("watchdog bit cleared"); // R4

  AST_SUB_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    !q[B0_SYS] |=> (!q[B0_SYS] || ($past(q[B0_SUBEN]) && $past(sub_stable))))
    else $error("unsafe switch to sub clock"); // R5

  AST_MAIN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    q[B0_SYS] |=> (q[B0_SYS] || (!$past(q[B0_MSTOP]) && $past(main_stable))))
    else $error("unsafe switch to main clock"); // R6

  AST_MSTOP_ON_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    !q[B0_MSTOP] |=> (!q[B0_MSTOP] || $past(q[B0_SYS])))
    else $error("main stopped while in use"); // R7

  AST_NO_FLIP45: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && flip45 && !stop_enter) |=> $stable(q)) else $error("both osc bits changed"); // R8

endmodule

// File: rtl/clkctl_reg1.sv
module clkctl_reg1
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             wake,
  input  logic             speed_hm,
  output logic [REG_W-1:0] q,
  output logic             stop_enter
);

  assign stop_enter = wr && wdata[B1_STOP] && !q[B1_STOP] && !wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTL1_RST;
    else begin
      if (wr)                      q <= ctl1_clean(wdata);
      if (stop_enter && speed_hm)  q[B1_MDRV] <= 1'b1;
      if (wake)                    q[B1_STOP] <= 1'b0;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~CTL1_KEEP) == '0) else $error("reserved bit set"); // R10

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !q[B1_STOP]) else $error("wake ignored"); // R12

  AST_STOP_MDRV: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_enter && speed_hm) |=> q[B1_MDRV]) else $error("main drive not forced"); // R11

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import clkctl_pkg::*;
#(
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_CTL0 = 0,
  parameter logic [ADDR_W-1:0] A_CTL1 = 1,
  parameter logic [ADDR_W-1:0] A_PROT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  input  logic              sub_stable,
  input  logic              main_stable,
  input  logic              speed_hm,
  input  logic              wake,
  output logic [1:0]        clkout_sel,
  output logic              wait_periph_stop,
  output logic              sub_drive_hi,
  output logic              sub_osc_en,
  output logic              main_osc_stop,
  output logic              wdt_reset_mode,
  output logic              sysclk_sub,
  output logic              main_drive_hi,
  output logic              stop_req,
  output logic              div8_load,
  output logic              wr_err
);

  logic             prot_en, wr_ctl0, wr_ctl1;
  logic [REG_W-1:0] ctl0_q, ctl1_q;
  logic             rej0, mstop_rise, stop_enter;
  cko_sel_e         cko;

  clkctl_decode #(.ADDR_W(ADDR_W), .A_CTL0(A_CTL0), .A_CTL1(A_CTL1), .A_PROT(A_PROT)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
    .prot_en(prot_en), .wr_ctl0(wr_ctl0), .wr_ctl1(wr_ctl1)
  );

  clkctl_reg0 u_r0 (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctl0), .wdata(wdata),
    .sub_stable(sub_stable), .main_stable(main_stable), .stop_enter(stop_enter),
    .q(ctl0_q), .rej(rej0), .mstop_rise(mstop_rise)
  );

  clkctl_reg1 u_r1 (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctl1), .wdata(wdata),
    .wake(wake), .speed_hm(speed_hm), .q(ctl1_q), .stop_enter(stop_enter)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div8_load <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      div8_load <= mstop_rise || stop_enter;
      wr_err    <= rej0;
    end
  end

  assign cko              = cko_sel_e'(ctl0_q[1:0]);
  assign clkout_sel       = cko;
  assign wait_periph_stop = ctl0_q[B0_WAITSTOP];
  assign sub_drive_hi     = ctl0_q[B0_SUBDRV];
  assign sub_osc_en       = ctl0_q[B0_SUBEN];
  assign main_osc_stop    = ctl0_q[B0_MSTOP];
  assign wdt_reset_mode   = ctl0_q[B0_WDT];
  assign sysclk_sub       = ctl0_q[B0_SYS];
  assign main_drive_hi    = ctl1_q[B1_MDRV];
  assign stop_req         = ctl1_q[B1_STOP];

  always_comb begin
    if (addr == A_CTL0)      rd_data = ctl0_q;
    else if (addr == A_CTL1) rd_data = ctl1_q;
    else if (addr == A_PROT) rd_data = {7'b0, prot_en};
    else                     rd_data = '0;
  end

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> ($stable(ctl0_q) && (ctl1_q[B1_MDRV] == $past(ctl1_q[B1_MDRV]))))
    else $error("write passed a clear protect bit"); // R2

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rej0 |=> (wr_err && $stable(ctl0_q))) else $error("refused write altered state"); // R9

  AST_DIV8_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_osc_stop) |-> div8_load) else $error("divide-by-8 not loaded"); // R13

  AST_STOP_SUBDRV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> sub_drive_hi) else $error("sub drive not forced"); // R11

endmodule

// File: tb/tb_sysclk_ctrl.sv
`timescale 1ns/1ps
module tb_sysclk_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       sub_stable = 1'b0, main_stable = 1'b1, speed_hm = 1'b1, wake = 1'b0;
  logic [1:0] clkout_sel;
  logic       wait_periph_stop, sub_drive_hi, sub_osc_en, main_osc_stop;
  logic       wdt_reset_mode, sysclk_sub, main_drive_hi, stop_req, div8_load, wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m0 = 8, m1 = 32, mp = 0, e_err = 0, e_d8 = 0;

  always #2.5 clk = ~clk;

  sysclk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .sub_stable(sub_stable), .main_stable(main_stable), .speed_hm(speed_hm), .wake(wake),
    .clkout_sel(clkout_sel), .wait_periph_stop(wait_periph_stop), .sub_drive_hi(sub_drive_hi),
    .sub_osc_en(sub_osc_en), .main_osc_stop(main_osc_stop), .wdt_reset_mode(wdt_reset_mode),
    .sysclk_sub(sysclk_sub), .main_drive_hi(main_drive_hi), .stop_req(stop_req),
    .div8_load(div8_load), .wr_err(wr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bitv(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  function automatic int model_read(input int a);
    case (a)
      0: return m0;
      1: return m1;
      2: return mp;
      default: return 0;
    endcase
  endfunction

  // model update on each edge, then compare a little later
  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = 8; m1 = 32; mp = 0; e_err = 0; e_d8 = 0;
    end else begin
      int oldp;
      oldp  = mp;
      e_err = 0;
      e_d8  = 0;
      if (wr_en && addr == 2) mp = wdata[0];
      if (wr_en && addr == 0 && oldp == 1) begin
        int w;
        bit bad;
        w   = wdata;
        bad = 0;
        if (bitv(m0, 4) != bitv(w, 4) && bitv(m0, 5) != bitv(w, 5)) bad = 1;
        if (bitv(m0, 7) == 0 && bitv(w, 7) == 1 && !(bitv(m0, 4) == 1 && sub_stable)) bad = 1;
        if (bitv(m0, 7) == 1 && bitv(w, 7) == 0 && !(bitv(m0, 5) == 0 && main_stable)) bad = 1;
        if (bitv(m0, 5) == 0 && bitv(w, 5) == 1 && bitv(m0, 7) == 0) bad = 1;
        if (bad) e_err = 1;
        else begin
          if (bitv(m0, 5) == 0 && bitv(w, 5) == 1) e_d8 = 1;
          m0 = w | (m0 & 64);
        end
      end
      if (wr_en && addr == 1 && oldp == 1) begin
        bit enter;
        enter = wdata[0] && bitv(m1, 0) == 0 && !wake;
        m1 = wdata & 8'h21;
        if (enter) begin
          m0 = m0 | 8;
          if (speed_hm) m1 = m1 | 32;
          e_d8 = 1;
        end
      end
      if (wake) m1 = m1 & ~1;
    end
    #1;
    chk("R3 reg0 outputs",
        {sysclk_sub, wdt_reset_mode, main_osc_stop, sub_osc_en, sub_drive_hi, wait_periph_stop, clkout_sel}, m0);
    chk("R10 reg1 outputs", {main_drive_hi, stop_req}, bitv(m1, 5) * 2 + bitv(m1, 0));
    chk("R9 wr_err", wr_err, e_err);
    chk("R13 div8_load", div8_load, e_d8);
    chk("R1 rd_data", rd_data, model_read(addr));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = a[3:0]; wdata = d[7:0]; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_reg(input string req, input int a, input int exp);
    addr = a[3:0];
    #0.5;
    chk(req, rd_data, exp);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg("R1 reset reg0", 0, 8'h08);
    expect_reg("R1 reset reg1", 1, 8'h20);
    expect_reg("R1 reset prot", 2, 8'h00);
    expect_reg("R1 unused addr", 5, 8'h00);

    wr(0, 8'h01);                       expect_reg("R2 locked write", 0, 8'h08);
    wr(2, 8'hFF);                       expect_reg("R2 prot keeps bit0", 2, 8'h01);
    wr(0, 8'h09);                       chk("R3 select fC", clkout_sel, 1);
    wr(0, 8'h0A);                       chk("R3 select f8", clkout_sel, 2);
    wr(0, 8'h0B);                       chk("R3 select f32", clkout_sel, 3);
    wr(0, 8'h8B);                       chk("R5 sub disabled err", wr_err, 1);
    expect_reg("R9 refused keeps reg0", 0, 8'h0B);
    wr(0, 8'h1B);                       expect_reg("R3 sub enable", 0, 8'h1B);
    wr(0, 8'h9B);                       expect_reg("R5 sub unstable", 0, 8'h1B);
    wr(0, 8'h3B);                       expect_reg("R7 main stop on main", 0, 8'h1B);
    sub_stable = 1'b1;
    wr(0, 8'h9B);                       chk("R5 switch to sub", sysclk_sub, 1);
    wr(0, 8'hAB);                       expect_reg("R8 both osc bits", 0, 8'h9B);
    wr(0, 8'hBB);                       chk("R13 div8 on main stop", div8_load, 1);
    expect_reg("R7 main stop on sub", 0, 8'hBB);
    wr(0, 8'hFB);                       chk("R4 watchdog set", wdt_reset_mode, 1);
    wr(0, 8'hBB);                       expect_reg("R4 watchdog sticky", 0, 8'hFB);
    wr(0, 8'h7B);                       expect_reg("R6 main still stopped", 0, 8'hFB);
    wr(0, 8'hDB);                       expect_reg("R6 main restarted", 0, 8'hDB);
    main_stable = 1'b0;
    wr(0, 8'h5B);                       expect_reg("R6 main unstable", 0, 8'hDB);
    main_stable = 1'b1;
    wr(0, 8'h5B);                       chk("R6 back to main", sysclk_sub, 0);
    wr(0, 8'h53);
    wr(1, 8'h00);                       expect_reg("R10 drive cleared", 1, 8'h00);
    wr(1, 8'hFF);                       chk("R13 div8 on stop", div8_load, 1);
    expect_reg("R10 R11 stop high speed", 1, 8'h21);
    expect_reg("R11 sub drive forced", 0, 8'h5B);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    expect_reg("R12 wake clears", 1, 8'h20);
    wr(0, 8'h53);
    wr(1, 8'h00);
    speed_hm = 1'b0;
    wr(1, 8'h01);                       expect_reg("R11 stop low speed", 1, 8'h01);
    expect_reg("R11 sub drive forced low speed", 0, 8'h5B);
    @(negedge clk); addr = 4'd1; wdata = 8'h21; wr_en = 1'b1; wake = 1'b1;
    @(negedge clk); wr_en = 1'b0; wake = 1'b0;
    expect_reg("R12 wake beats write", 1, 8'h20);
    wr(2, 8'h00);
    wr(1, 8'h01);                       expect_reg("R2 reg1 locked", 1, 8'h20);

    // randomised phase, compared each clock by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      addr        = 4'($urandom_range(0, 3));
      wdata       = 8'($urandom);
      wr_en       = ($urandom_range(0, 3) != 0);
      sub_stable  = ($urandom_range(0, 3) != 0);
      main_stable = ($urandom_range(0, 3) != 0);
      speed_hm    = $urandom_range(0, 1) == 1;
      wake        = ($urandom_range(0, 9) == 0);
    end
    @(negedge clk);
    wr_en = 1'b0; wake = 1'b0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule